// File: doc/BRIEF.md
# Byte-Link Transmit End-of-Frame Sequencer

This block drives the transmit side of a byte-oriented serial data link. A host writes bytes one at a time. The first byte goes straight into a transmit shift register. A second byte written while the shift register is busy waits in a one-byte shadow register. Bits leave most significant bit first over a valid/ready handshake toward a bit-level line interface. The line interface handles symbol timing and arbitration itself.

When the host strobes an end-of-frame request, the sequencer lets every queued data byte drain. It then sends one inverted CRC-8 byte and raises a one-cycle request for an end-of-data symbol. The block also stores a three-bit response-type selection, with priority resolution for illegal combinations. From that selection and a polarity select it produces the normalization bit. The response type decides how long the end-of-frame request stays pending. Two single-cycle pulses come in from outside: echo-back of a valid end-of-data symbol, and a detected error.

Top module: `bltx_eod_seq`

## Requirements
- R1: After reset, `tdre`=1, `eod_pend`=0, `crc_busy`=0, `bit_valid`=0, `eod_sym`=0 and `rtype_q`=000.
- R2: Each byte is sent most significant bit first. A bit counts as sent on a clock edge where `bit_valid` and `bit_ready` are both 1. While `bit_ready` is 0, `bit_valid` and `bit_out` hold their values.
- R3: A write made while the shift register is busy goes to the shadow register and clears `tdre`. The shadow byte follows the current byte with no idle cycle. When it moves into the shift register, `tdre` returns to 1 if no end-of-frame request is pending.
- R4: After an end-of-frame request, one CRC byte follows the last queued data byte. If the shadow register is full, that means after both the shift byte and the shadow byte. The CRC register uses polynomial x^8+x^4+x^3+x^2+1 (0x1D). It starts at 0xFF and is updated MSB first over each data byte of the frame. The byte sent is the bitwise inverse of the register.
- R5: An accepted end-of-frame request sets `eod_pend` and clears `tdre`. While `eod_pend` or `crc_busy` is 1, host writes are ignored.
- R6: When `rtype_q`=000, `eod_pend` falls in the same cycle that `crc_busy` rises, which is when the CRC byte enters the shift register. `crc_busy` stays 1 while the CRC byte is being sent.
- R7: When `rtype_q` is nonzero, `eod_pend` stays 1 after the CRC byte. It clears only on an `eod_echo` pulse that arrives after the CRC has been sent.
- R8: The cycle after the last CRC bit is accepted, `eod_sym` is 1 for exactly one cycle. `tdre` is 1 again from that cycle on.
- R9: `rtype_wr` stores `rtype_in` resolved by priority: bit 2 (single-byte response) wins over bit 1 (multi-byte response with CRC), which wins over bit 0 (multi-byte response without CRC). The stored value has at most one bit set.
- R10: With `nb_pol_sel`=1, `nb_bit` is 0 when `rtype_q`=010 (the response ends with a CRC) and 1 otherwise. With `nb_pol_sel`=0, `nb_bit` takes the inverse value.
- R11: An `err_pulse` empties the shift and shadow registers, resets the CRC to 0xFF, clears `eod_pend` and `crc_busy`, and sets `tdre`. The next frame's CRC starts from 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| eod_set | input | 1 | End-of-frame request strobe |
| rtype_wr | input | 1 | Response-type write strobe |
| rtype_in | input | 3 | Requested response-type bits |
| nb_pol_sel | input | 1 | Normalization-bit polarity select |
| eod_echo | input | 1 | Valid end-of-data symbol received back |
| err_pulse | input | 1 | Error detected |
| bit_ready | input | 1 | Line interface accepts a bit |
| bit_valid | output | 1 | Bit on `bit_out` is valid |
| bit_out | output | 1 | Serial data bit |
| eod_sym | output | 1 | One-cycle end-of-data symbol request |
| tdre | output | 1 | Data register empty flag |
| eod_pend | output | 1 | End-of-frame request pending |
| crc_busy | output | 1 | CRC byte in the shift register |
| rtype_q | output | 3 | Stored response type |
| nb_bit | output | 1 | Normalization bit value |

## Verification
The bench sends a two-byte frame with the end-of-frame request raised while the shadow is full. This separates correct CRC deferral from a CRC that cuts in after the shift byte alone. A one-byte frame with `bit_ready` toggling shows that the stream is unchanged by stalls, and that writes during a pending request are dropped. A frame under a nonzero response type tells the echo-held request apart from the request that clears itself at CRC start. An error in the middle of a frame, followed by a fresh frame, shows whether the CRC register and the queues really restart. Several conflicting response-type patterns, each under both polarity selects, exercise the priority resolution and the normalization bit.

// File: rtl/bltx_pkg.sv
// Shared constants for the byte-link transmit end-of-frame sequencer.
// Assumes an 8-bit byte and a three-bit one-hot response-type field.
package bltx_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned RTYPE_W   = 3;
    localparam logic [7:0]  CRC_POLY  = 8'h1D;
    localparam logic [7:0]  CRC_INIT  = 8'hFF;
    // Index of the response type whose response ends with a CRC byte.
    localparam int unsigned RTYPE_CRC_IDX = 1;
endpackage

// File: rtl/bltx_crc.sv
// CRC register for transmitted data bytes.
// Folds one whole byte per update, MSB first. clr returns it to INIT
// and wins over upd. Assumes upd comes at most once per byte.
module bltx_crc #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] POLY = 8'h1D,
    parameter logic [W-1:0] INIT = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q
);
    logic [W-1:0] crc_nx;

    // Purpose: serial CRC step unrolled over the W bits of din.
    always_comb begin
        crc_nx = crc_q;
        for (int i = W - 1; i >= 0; i--) begin
            if (crc_nx[W-1] ^ din[i])
                crc_nx = (crc_nx << 1) ^ POLY;
            else
                crc_nx = crc_nx << 1;
        end
    end

    // Purpose: hold the running CRC value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc_q <= INIT;
        else if (upd)
            crc_q <= crc_nx;
    end

    AST_CRC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == INIT)); // R11
endmodule

// File: rtl/bltx_ifr_ctl.sv
// Response-type store and normalization-bit select.
// A write keeps only the highest set request bit, so the stored field
// is always one-hot or zero. Assumes the highest index has top priority.
module bltx_ifr_ctl #(
    parameter int unsigned N       = 3,
    parameter int unsigned CRC_IDX = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rtype_wr,
    input  logic [N-1:0] rtype_in,
    input  logic         nb_pol_sel,
    output logic [N-1:0] rtype_q,
    output logic         nb_bit,
    output logic         ifr_active
);
    logic [N-1:0] rtype_res;
    logic         ends_crc;

    // Purpose: priority resolution, higher index overrides lower.
    always_comb begin
        rtype_res = '0;
        for (int i = 0; i < N; i++) begin
            if (rtype_in[i])
                rtype_res = N'(1) << i;
        end
    end

    // Purpose: store the resolved response type.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rtype_q <= '0;
        else if (rtype_wr)
            rtype_q <= rtype_res;
    end

    assign ends_crc   = rtype_q[CRC_IDX];
    assign nb_bit     = nb_pol_sel ? ~ends_crc : ends_crc;
    assign ifr_active = |rtype_q;

    AST_RTYPE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rtype_q)); // R9
    AST_RTYPE_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rtype_wr && rtype_in[N-1]) |=> rtype_q[N-1]); // R9
endmodule

// File: rtl/bltx_shifter.sv
// Transmit shift register with bit counter and valid/ready handshake.
// load takes priority over the shift. done marks the accept of the last bit.
// Assumes load is asserted only when the register is empty or finishing.
module bltx_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         bit_ready,
    output logic         full,
    output logic         bit_out,
    output logic         done
);
    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept  = full && bit_ready;
    assign done    = accept && (cnt == CNT_W'(W - 1));
    assign bit_out = sreg[W-1];

    // Purpose: load, shift and count bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sreg <= '0;
            cnt  <= '0;
            full <= 1'b0;
        end else if (load) begin
            sreg <= load_data;
            cnt  <= '0;
            full <= 1'b1;
        end else if (accept) begin
            sreg <= sreg << 1;
            cnt  <= cnt + 1'b1;
            if (done)
                full <= 1'b0;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !bit_ready && !clr && !load) |=> (full && $stable(bit_out))); // R2
endmodule

// File: rtl/bltx_eod_seq.sv
// Byte-link transmit end-of-frame sequencer (top).
// Queues host bytes in a shift register and a one-byte shadow, sends them
// MSB first, and on an end-of-frame request appends an inverted CRC-8 byte
// and then pulses an end-of-data symbol request. Assumes err_pulse and
// eod_echo are single-cycle pulses from the line side.
module bltx_eod_seq
    import bltx_pkg::*;
#(
    parameter int unsigned DATA_W   = BYTE_W,
    parameter int unsigned TYPE_W   = RTYPE_W,
    parameter int unsigned CRC_IDX  = RTYPE_CRC_IDX,
    parameter logic [DATA_W-1:0] POLY = CRC_POLY,
    parameter logic [DATA_W-1:0] INIT = CRC_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eod_set,
    input  logic              rtype_wr,
    input  logic [TYPE_W-1:0] rtype_in,
    input  logic              nb_pol_sel,
    input  logic              eod_echo,
    input  logic              err_pulse,
    input  logic              bit_ready,
    output logic              bit_valid,
    output logic              bit_out,
    output logic              eod_sym,
    output logic              tdre,
    output logic              eod_pend,
    output logic              crc_busy,
    output logic [TYPE_W-1:0] rtype_q,
    output logic              nb_bit
);
    logic [DATA_W-1:0] shd_data;
    logic              shd_full;
    logic              crc_sent;
    logic              sh_done;
    logic              ifr_active;
    logic [DATA_W-1:0] crc_q;
    logic              shift_free, wr_ok, load_shadow, load_direct, wr_to_shadow;
    logic              crc_load, crc_end, eod_ok, sh_load;
    logic [DATA_W-1:0] sh_load_data;

    bltx_ifr_ctl #(.N(TYPE_W), .CRC_IDX(CRC_IDX)) u_ifr (
        .clk(clk), .rst_n(rst_n), .rtype_wr(rtype_wr), .rtype_in(rtype_in),
        .nb_pol_sel(nb_pol_sel), .rtype_q(rtype_q), .nb_bit(nb_bit),
        .ifr_active(ifr_active)
    );

    bltx_crc #(.W(DATA_W), .POLY(POLY), .INIT(INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_end || err_pulse),
        .upd(load_shadow || load_direct), .din(sh_load_data), .crc_q(crc_q)
    );

    bltx_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(err_pulse), .load(sh_load),
        .load_data(sh_load_data), .bit_ready(bit_ready), .full(bit_valid),
        .bit_out(bit_out), .done(sh_done)
    );

    // Purpose: decide what, if anything, enters the shift register this cycle.
    always_comb begin
        shift_free   = !bit_valid || sh_done;
        wr_ok        = wr_valid && !eod_pend && !crc_busy && !shd_full && !err_pulse;
        load_shadow  = shift_free && shd_full && !err_pulse;
        load_direct  = shift_free && !shd_full && wr_ok;
        wr_to_shadow = wr_ok && !load_direct;
        crc_load     = shift_free && !shd_full && eod_pend && !crc_sent
                       && !crc_busy && !err_pulse;
        crc_end      = sh_done && crc_busy && !err_pulse;
        eod_ok       = eod_set && !eod_pend && !crc_busy && !err_pulse;
        sh_load      = load_shadow || load_direct || crc_load;
        if (load_shadow)
            sh_load_data = shd_data;
        else if (load_direct)
            sh_load_data = wr_data;
        else
            sh_load_data = ~crc_q;
    end

    // Purpose: shadow byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || err_pulse) begin
            shd_full <= 1'b0;
            shd_data <= '0;
        end else if (wr_to_shadow) begin
            shd_full <= 1'b1;
            shd_data <= wr_data;
        end else if (load_shadow) begin
            shd_full <= 1'b0;
        end
    end

    // Purpose: end-of-frame request, CRC phase and symbol pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || err_pulse) begin
            eod_pend <= 1'b0;
            crc_sent <= 1'b0;
            crc_busy <= 1'b0;
            eod_sym  <= 1'b0;
        end else begin
            eod_sym <= crc_end;
            if (eod_ok) begin
                eod_pend <= 1'b1;
                crc_sent <= 1'b0;
            end else if (crc_load && !ifr_active) begin
                eod_pend <= 1'b0;
            end else if (eod_echo && ifr_active && crc_sent && !crc_busy) begin
                eod_pend <= 1'b0;
            end
            if (crc_load) begin
                crc_sent <= 1'b1;
                crc_busy <= 1'b1;
            end else if (crc_end) begin
                crc_busy <= 1'b0;
            end
        end
    end

    // Purpose: data-register-empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n || err_pulse)
            tdre <= 1'b1;
        else if (eod_ok || wr_to_shadow)
            tdre <= 1'b0;
        else if (crc_end || (load_shadow && !eod_pend))
            tdre <= 1'b1;
    end

    AST_EOD_SET_CLR_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
        eod_ok |=> (eod_pend && !tdre)); // R5
    AST_NORMAL_EOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(crc_busy) && (rtype_q == '0)) |-> !eod_pend); // R6
    AST_SYM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eod_sym |=> !eod_sym); // R8
    AST_ERR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> (!bit_valid && tdre && !eod_pend && !crc_busy)); // R11
endmodule

// File: tb/bltx_eod_seq_tb.sv
module bltx_eod_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       eod_set = 1'b0;
    logic       rtype_wr = 1'b0;
    logic [2:0] rtype_in = '0;
    logic       nb_pol_sel = 1'b0;
    logic       eod_echo = 1'b0;
    logic       err_pulse = 1'b0;
    logic       bit_ready = 1'b1;
    logic       bit_valid, bit_out, eod_sym, tdre, eod_pend, crc_busy, nb_bit;
    logic [2:0] rtype_q;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic cap_bit [0:2047];
    int   nbits = 0;
    int   nsym = 0;
    logic prev_crc_busy = 1'b0;
    logic eod_at_crc = 1'b0;

    bltx_eod_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .eod_set(eod_set), .rtype_wr(rtype_wr), .rtype_in(rtype_in),
        .nb_pol_sel(nb_pol_sel), .eod_echo(eod_echo), .err_pulse(err_pulse),
        .bit_ready(bit_ready), .bit_valid(bit_valid), .bit_out(bit_out),
        .eod_sym(eod_sym), .tdre(tdre), .eod_pend(eod_pend),
        .crc_busy(crc_busy), .rtype_q(rtype_q), .nb_bit(nb_bit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Line-side monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && bit_valid && bit_ready && nbits < 2048) begin
            cap_bit[nbits] = bit_out;
            nbits = nbits + 1;
        end
        if (rst_n && eod_sym) nsym = nsym + 1;
        if (rst_n && crc_busy && !prev_crc_busy) eod_at_crc = eod_pend;
        prev_crc_busy = crc_busy;
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] b [], input int n);
        logic [7:0] c = 8'hFF;
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) begin
                logic fb = c[7] ^ b[k][i];
                c = c << 1;
                if (fb) c = c ^ 8'h1D;
            end
        return ~c;
    endfunction

    function automatic logic [7:0] cap_byte(input int start);
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) v = {v[6:0], cap_bit[start + i]};
        return v;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic to_sample();
        @(negedge clk); #1;
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d; tick(); wr_valid = 1'b0;
    endtask

    task automatic pulse_eod();
        eod_set = 1'b1; tick(); eod_set = 1'b0;
    endtask

    task automatic set_rtype(input logic [2:0] v);
        rtype_in = v; rtype_wr = 1'b1; tick(); rtype_wr = 1'b0;
    endtask

    task automatic wait_sym(input int start_sym, input bit toggle_ready);
        for (int i = 0; i < 600 && nsym == start_sym; i++) begin
            if (toggle_ready) bit_ready = ~bit_ready;
            tick();
        end
        bit_ready = 1'b1;
    endtask

    task automatic check_stream(input logic [7:0] exp [], input int n, input int base, input string tag);
        chk(nbits - base == n * 8, {tag, " bit count"}, nbits - base, n * 8);
        for (int k = 0; k < n; k++)
            chk(cap_byte(base + 8 * k) == exp[k], {tag, " byte"}, cap_byte(base + 8 * k), exp[k]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
        to_sample();
        chk(tdre && !eod_pend && !crc_busy && !bit_valid && !eod_sym && rtype_q == 3'b000,
            "R1 reset state", {tdre, eod_pend, crc_busy, bit_valid, eod_sym}, 5'b10000);
    endtask

    task automatic t_shadow_flow();
        int base;
        logic [7:0] exp [];
        base = nbits;
        exp = new[3];
        exp[0] = 8'h11; exp[1] = 8'h22;
        exp[2] = ref_crc(exp, 2);
        tick();
        write_byte(8'h11);
        write_byte(8'h22);
        to_sample();
        chk(tdre == 1'b0, "R3 tdre clears on shadow fill", tdre, 0);
        for (int i = 0; i < 12; i++) tick();
        to_sample();
        chk(tdre == 1'b1, "R3 tdre sets when shadow moves", tdre, 1);
        tick();
        pulse_eod();
        wait_sym(nsym, 1'b0);
        check_stream(exp, 3, base, "R3 R2 back-to-back stream");
    endtask

    task automatic t_deferred_crc();
        int base, s0;
        logic [7:0] exp [];
        base = nbits; s0 = nsym;
        exp = new[3];
        exp[0] = 8'hA1; exp[1] = 8'hB2;
        exp[2] = ref_crc(exp, 2);
        tick();
        write_byte(8'hA1);
        write_byte(8'hB2);
        pulse_eod();
        to_sample();
        chk(eod_pend == 1'b1 && tdre == 1'b0, "R5 eod set clears tdre", {eod_pend, tdre}, 2'b10);
        chk(crc_busy == 1'b0, "R4 CRC waits behind shadow", crc_busy, 0);
        wait_sym(s0, 1'b0);
        check_stream(exp, 3, base, "R4 deferred CRC");
        chk(eod_at_crc == 1'b0, "R6 eod_pend clears at CRC start", eod_at_crc, 0);
        to_sample();
        chk(nsym - s0 == 1 && eod_sym == 1'b0, "R8 single eod_sym pulse", nsym - s0, 1);
        chk(tdre == 1'b1 && eod_pend == 1'b0, "R8 tdre back after frame", {tdre, eod_pend}, 2'b10);
    endtask

    task automatic t_stall_and_ignore();
        int base, s0;
        logic [7:0] exp [];
        base = nbits; s0 = nsym;
        exp = new[2];
        exp[0] = 8'h3C;
        exp[1] = ref_crc(exp, 1);
        tick();
        write_byte(8'h3C);
        pulse_eod();
        write_byte(8'hEE);
        wait_sym(s0, 1'b1);
        for (int i = 0; i < 20; i++) tick();
        to_sample();
        check_stream(exp, 2, base, "R5 R2 stalled stream, write ignored");
        chk(bit_valid == 1'b0, "R5 ignored write not queued", bit_valid, 0);
    endtask

    task automatic t_rtype_nb();
        set_rtype(3'b011); to_sample();
        chk(rtype_q == 3'b010, "R9 011 resolves", rtype_q, 3'b010);
        nb_pol_sel = 1'b1; to_sample();
        chk(nb_bit == 1'b0, "R10 sel1 crc type", nb_bit, 0);
        nb_pol_sel = 1'b0; to_sample();
        chk(nb_bit == 1'b1, "R10 sel0 crc type", nb_bit, 1);
        tick(); set_rtype(3'b111); to_sample();
        chk(rtype_q == 3'b100, "R9 111 resolves", rtype_q, 3'b100);
        nb_pol_sel = 1'b1; to_sample();
        chk(nb_bit == 1'b1, "R10 sel1 non-crc type", nb_bit, 1);
        tick(); set_rtype(3'b001); to_sample();
        chk(rtype_q == 3'b001, "R9 001 kept", rtype_q, 3'b001);
        tick(); set_rtype(3'b101); to_sample();
        chk(rtype_q == 3'b100, "R9 101 resolves", rtype_q, 3'b100);
    endtask

    task automatic t_ifr_hold();
        int base, s0;
        logic [7:0] exp [];
        base = nbits; s0 = nsym;
        exp = new[2];
        exp[0] = 8'h55;
        exp[1] = ref_crc(exp, 1);
        tick();
        write_byte(8'h55);
        pulse_eod();
        wait_sym(s0, 1'b0);
        check_stream(exp, 2, base, "R7 response frame");
        chk(eod_at_crc == 1'b1, "R7 eod_pend held at CRC start", eod_at_crc, 1);
        for (int i = 0; i < 5; i++) tick();
        to_sample();
        chk(eod_pend == 1'b1, "R7 eod_pend held after CRC", eod_pend, 1);
        tick();
        eod_echo = 1'b1; tick(); eod_echo = 1'b0;
        to_sample();
        chk(eod_pend == 1'b0, "R7 echo clears eod_pend", eod_pend, 0);
        tick(); set_rtype(3'b000);
    endtask

    task automatic t_error();
        int base, s0;
        logic [7:0] exp [];
        s0 = nsym;
        tick();
        write_byte(8'h5A);
        write_byte(8'h6B);
        pulse_eod();
        for (int i = 0; i < 4; i++) tick();
        err_pulse = 1'b1; tick(); err_pulse = 1'b0;
        to_sample();
        chk(!bit_valid && tdre && !eod_pend && !crc_busy, "R11 error flush",
            {bit_valid, tdre, eod_pend, crc_busy}, 4'b0100);
        for (int i = 0; i < 30; i++) tick();
        to_sample();
        chk(nsym == s0 && !bit_valid, "R11 nothing sent after error", nsym - s0, 0);
        base = nbits; s0 = nsym;
        exp = new[2];
        exp[0] = 8'hC3;
        exp[1] = ref_crc(exp, 1);
        tick();
        write_byte(8'hC3);
        pulse_eod();
        wait_sym(s0, 1'b0);
        check_stream(exp, 2, base, "R11 CRC restarts after error");
    endtask

    initial begin
        t_reset();
        t_shadow_flow();
        t_deferred_crc();
        t_stall_and_ignore();
        t_rtype_nb();
        t_ifr_hold();
        t_error();
        for (int i = 0; i < 5; i++) tick();
        report();
        $finish;
    end
endmodule